// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupts

The block is a 32-line general-purpose I/O controller behind a simple 32-bit register bus with word-aligned byte addresses. Software owns an output data register. It can overwrite that register as a whole, or flip single bits atomically through separate set and clear ports. Input pins pass through a two-flop synchronizer and can be read back at any time. Two further registers are kept as plain storage and driven out to the pad ring as pull enable and pull direction.

Each line can raise an interrupt. Three per-line configuration bits choose the trigger: rising edge, falling edge, either edge, high level or low level. Edge events stay latched until software acknowledges them by writing ones to a clear register. Level events follow the pin for as long as the pin is active. Raw status shows every enabled line's event. A second status view removes the lines that the mask register blocks. The OR of that masked view drives the single interrupt output. An optional per-line debounce filter sits between the synchronizer and event detection. All filters share one programmable tick divider.

The bus read path is combinational: read data is valid in the same cycle as the address. A write takes effect at the clock edge where it is presented.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `dout_o`, `pull_en_o` and `pull_dir_o` are zero, and `irq_o` is low.
- R2: A write to byte offset 0x00 replaces the output data; a read of 0x00 and `dout_o` both return it.
- R3: Writing to 0x10 sets the output bits that are 1 in the write data. Writing to 0x14 clears the output bits that are 1. Bits that are 0 in either write keep their value. Both offsets read as zero.
- R4: A read of 0x04 returns the pins through a two-flop synchronizer. A pin change driven before clock edge k is visible after edge k+1 and not after edge k.
- R5: Offsets 0x18 (pull enable) and 0x1C (pull direction) are read/write storage that drive `pull_en_o` and `pull_dir_o`.
- R6: A line whose type bit (0x34) is 0 is edge triggered. If its both-edge bit (0x38) is 1, either edge is detected. Otherwise its polarity bit (0x3C) chooses the edge: 0 for rising, 1 for falling. The detected event stays latched in raw status (0x24).
- R7: A line whose type bit is 1 is level triggered. Polarity 0 means active high and 1 means active low. Its raw status follows the active condition of the line, and a write to the clear register has no effect on it.
- R8: Writing a 1 to a bit of 0x30 clears that line's latched edge status. Writing 0 bits leaves status unchanged. The register reads as zero.
- R9: A line whose enable bit (0x20) is 0 shows raw status 0 one cycle after the enable is observed low.
- R10: Masked status (0x28) is raw status with the lines whose mask bit (0x2C) is 1 removed. `irq_o` is high exactly when masked status is non-zero.
- R11: A line with debounce enabled (0x40) only takes a new filtered value once the same synchronized level has been seen on two consecutive ticks. A tick occurs every max(prescale,1) cycles, where prescale is the low 24 bits of 0x44. The filtered value of every line can be read at 0x0C; for lines without debounce it equals the synchronized pin.
- R12: With debounce disabled, a pin change driven before edge k sets raw status at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 7 | Byte address, low two bits ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 32 | Pin inputs |
| dout_o | output | 32 | Output data to pads |
| pull_en_o | output | 32 | Pull enable to pads |
| pull_dir_o | output | 32 | Pull direction to pads |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the edge where they are presented, so reads issued at the next falling edge see them. Pin changes cross two synchronizer flops before data-in shows them, and one more register before raw status latches. The bench drives pins at a falling edge. It then reads at the falling edges after the first, second and third rising edges, and requires the old value, the new data-in value and finally the status bit at those exact points. Disabling a line clears its status one edge after the enable register changes, so that check reads one further falling edge later. Debounce results are read after a long fixed wait that spans many ticks.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // word indices (byte offset >> 2)
  localparam int unsigned W_DOUT  = 0;
  localparam int unsigned W_DIN   = 1;
  localparam int unsigned W_FILT  = 3;
  localparam int unsigned W_SET   = 4;
  localparam int unsigned W_CLR   = 5;
  localparam int unsigned W_PEN   = 6;
  localparam int unsigned W_PDIR  = 7;
  localparam int unsigned W_IEN   = 8;
  localparam int unsigned W_RAW   = 9;
  localparam int unsigned W_MSTAT = 10;
  localparam int unsigned W_MASK  = 11;
  localparam int unsigned W_ICLR  = 12;
  localparam int unsigned W_TYPE  = 13;
  localparam int unsigned W_BOTH  = 14;
  localparam int unsigned W_POL   = 15;
  localparam int unsigned W_DEN   = 16;
  localparam int unsigned W_DPRE  = 17;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_tick.sv
module gpio_tick #(
  parameter int unsigned PRE_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q, lim;

  assign lim    = (pre_i == '0) ? '0 : pre_i - 1'b1;
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic d_i,
  output logic filt_o
);
  logic smp_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0;
      out_q <= 1'b0;
    end else if (!en_i) begin
      // track so enabling causes no spurious change
      smp_q <= d_i;
      out_q <= d_i;
    end else if (tick_i) begin
      smp_q <= d_i;
      if (smp_q == d_i) out_q <= d_i;
    end
  end

  assign filt_o = en_i ? out_q : d_i;

  p_filter_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> (en_i ? $stable(out_q) : 1'b1));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] type_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] prev_q, stat_q, rise, fall, edge_hit, lvl_act, stat_d;

  assign rise     = lvl_i & ~prev_q;
  assign fall     = ~lvl_i & prev_q;
  assign edge_hit = (both_i & (rise | fall)) | (~both_i & ((~pol_i & rise) | (pol_i & fall)));
  assign lvl_act  = lvl_i ^ pol_i;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!en_i[i])       stat_d[i] = 1'b0;
      else if (type_i[i]) stat_d[i] = lvl_act[i];
      else                stat_d[i] = edge_hit[i] | (stat_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  p_disabled_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |=> (stat_o == '0));
  p_edge_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(en_i & ~type_i & stat_o & ~clr_i))
              == $past(en_i & ~type_i & stat_o & ~clr_i)));
  p_level_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & $past(en_i & type_i & ~pol_i & ~lvl_i)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned PRE_W   = 24,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [N_LINES-1:0] pin_i,
  output logic [N_LINES-1:0] dout_o,
  output logic [N_LINES-1:0] pull_en_o,
  output logic [N_LINES-1:0] pull_dir_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx;
  logic               wr;
  logic [N_LINES-1:0] wv;
  logic [N_LINES-1:0] dout_q, pen_q, pdir_q, ien_q, mask_q, type_q, both_q, pol_q, den_q;
  logic [PRE_W-1:0]   pre_q;
  logic [N_LINES-1:0] sync_v, filt_v, raw_v, mstat_v, clr_v;
  logic               tick;

  assign idx = addr_i[ADDR_W-1:2];
  assign wr  = req_i & we_i;
  assign wv  = wdata_i[N_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0; pen_q  <= '0; pdir_q <= '0; ien_q <= '0; mask_q <= '0;
      type_q <= '0; both_q <= '0; pol_q  <= '0; den_q <= '0; pre_q  <= '0;
    end else if (wr) begin
      case (idx)
        IDX_W'(W_DOUT): dout_q <= wv;
        IDX_W'(W_SET):  dout_q <= dout_q | wv;
        IDX_W'(W_CLR):  dout_q <= dout_q & ~wv;
        IDX_W'(W_PEN):  pen_q  <= wv;
        IDX_W'(W_PDIR): pdir_q <= wv;
        IDX_W'(W_IEN):  ien_q  <= wv;
        IDX_W'(W_MASK): mask_q <= wv;
        IDX_W'(W_TYPE): type_q <= wv;
        IDX_W'(W_BOTH): both_q <= wv;
        IDX_W'(W_POL):  pol_q  <= wv;
        IDX_W'(W_DEN):  den_q  <= wv;
        IDX_W'(W_DPRE): pre_q  <= wdata_i[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_v = (wr && idx == IDX_W'(W_ICLR)) ? wv : '0;

  gpio_sync2 #(.WIDTH(N_LINES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_v)
  );

  gpio_tick #(.PRE_W(PRE_W)) i_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_i(pre_q), .tick_o(tick)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_deb
    gpio_debounce i_deb (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(den_q[g]), .tick_i(tick),
      .d_i(sync_v[g]), .filt_o(filt_v[g])
    );
  end

  gpio_evt_detect #(.N(N_LINES)) i_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(filt_v), .en_i(ien_q),
    .type_i(type_q), .pol_i(pol_q), .both_i(both_q), .clr_i(clr_v),
    .stat_o(raw_v)
  );

  assign mstat_v = raw_v & ~mask_q;
  assign irq_o   = |mstat_v;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      case (idx)
        IDX_W'(W_DOUT):  rdata_o[N_LINES-1:0] = dout_q;
        IDX_W'(W_DIN):   rdata_o[N_LINES-1:0] = sync_v;
        IDX_W'(W_FILT):  rdata_o[N_LINES-1:0] = filt_v;
        IDX_W'(W_PEN):   rdata_o[N_LINES-1:0] = pen_q;
        IDX_W'(W_PDIR):  rdata_o[N_LINES-1:0] = pdir_q;
        IDX_W'(W_IEN):   rdata_o[N_LINES-1:0] = ien_q;
        IDX_W'(W_RAW):   rdata_o[N_LINES-1:0] = raw_v;
        IDX_W'(W_MSTAT): rdata_o[N_LINES-1:0] = mstat_v;
        IDX_W'(W_MASK):  rdata_o[N_LINES-1:0] = mask_q;
        IDX_W'(W_TYPE):  rdata_o[N_LINES-1:0] = type_q;
        IDX_W'(W_BOTH):  rdata_o[N_LINES-1:0] = both_q;
        IDX_W'(W_POL):   rdata_o[N_LINES-1:0] = pol_q;
        IDX_W'(W_DEN):   rdata_o[N_LINES-1:0] = den_q;
        IDX_W'(W_DPRE):  rdata_o[PRE_W-1:0]   = pre_q;
        default: ;
      endcase
    end
  end

  assign dout_o     = dout_q;
  assign pull_en_o  = pen_q;
  assign pull_dir_o = pdir_q;

  p_set_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_W'(W_SET)) |=> ((dout_o & $past(wv)) == $past(wv)));
  p_clr_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && idx == IDX_W'(W_CLR)) |=> ((dout_o & $past(wv)) == '0));
  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_v == '0) |-> !irq_o);
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pins = '0, dout, pen, pdir;
  logic        irq;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .dout_o(dout),
    .pull_en_o(pen), .pull_dir_o(pdir), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(7'h00, v); chk("R1 dout reg", v, 0);
    rd(7'h20, v); chk("R1 enable reg", v, 0);
    rd(7'h44, v); chk("R1 prescale reg", v, 0);
    chk("R1 dout_o", dout, 0);
    chk("R1 pulls", pen | pdir, 0);
    chk("R1 irq_o", {31'b0, irq}, 0);
  endtask

  task automatic t_dout;
    logic [31:0] v;
    wr(7'h00, 32'hA5A5_0F0F);
    rd(7'h00, v); chk("R2 readback", v, 32'hA5A5_0F0F);
    chk("R2 dout_o", dout, 32'hA5A5_0F0F);
  endtask

  task automatic t_setclr;
    logic [31:0] v;
    wr(7'h10, 32'h0000_00F0);
    chk("R3 set", dout, 32'hA5A5_0FFF);
    wr(7'h14, 32'h8000_000F);
    chk("R3 clear", dout, 32'h25A5_0FF0);
    rd(7'h10, v); chk("R3 set reads zero", v, 0);
    rd(7'h14, v); chk("R3 clear reads zero", v, 0);
  endtask

  task automatic t_din;
    logic [31:0] v;
    @(negedge clk); pins = 32'h1234_5678;
    rd(7'h04, v); chk("R4 after one edge", v, 0);
    rd(7'h04, v); chk("R4 after two edges", v, 32'h1234_5678);
    @(negedge clk); pins = '0;
    idle(4);
  endtask

  task automatic t_pull;
    logic [31:0] v;
    wr(7'h18, 32'hDEAD_0001);
    wr(7'h1C, 32'h0000_BEEF);
    rd(7'h18, v); chk("R5 pull enable reg", v, 32'hDEAD_0001);
    chk("R5 pull_en_o", pen, 32'hDEAD_0001);
    chk("R5 pull_dir_o", pdir, 32'h0000_BEEF);
  endtask

  task automatic t_trig;
    logic [31:0] v;
    // line0 rise, line1 fall, line2 both, line3 level high, line4 level low
    wr(7'h34, 32'h18);
    wr(7'h3C, 32'h12);
    wr(7'h38, 32'h04);
    wr(7'h20, 32'h1F);
    wr(7'h30, 32'hFFFF_FFFF);
    rd(7'h24, v); chk("R7 low level active at idle", v, 32'h10);
    @(negedge clk); pins = 32'h0F;
    rd(7'h24, v);
    rd(7'h24, v); chk("R12 not yet after two edges", v, 32'h10);
    rd(7'h24, v); chk("R12/R6/R7 after three edges", v, 32'h1D);
    @(negedge clk); pins = 32'h00;
    idle(4);
    rd(7'h24, v); chk("R6 latched rise, fall, both; R7 level drop", v, 32'h17);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(7'h30, 32'h11);
    rd(7'h24, v); chk("R8 edge cleared, R7 level kept", v, 32'h16);
    wr(7'h30, 32'h0);
    rd(7'h24, v); chk("R8 zero write no effect", v, 32'h16);
    rd(7'h30, v); chk("R8 clear reads zero", v, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(7'h2C, 32'h06);
    rd(7'h28, v); chk("R10 masked status", v, 32'h10);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(7'h2C, 32'h16);
    rd(7'h28, v); chk("R10 all masked", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    rd(7'h24, v); chk("R10 raw unaffected by mask", v, 32'h16);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(7'h20, 32'h0);
    rd(7'h24, v); chk("R9 disabled lines report nothing", v, 0);
  endtask

  task automatic t_debounce;
    logic [31:0] v;
    wr(7'h2C, 0); wr(7'h34, 0); wr(7'h3C, 0); wr(7'h38, 0);
    wr(7'h44, 32'd4);
    wr(7'h40, 32'h20);
    wr(7'h20, 32'h20);
    wr(7'h30, 32'hFFFF_FFFF);
    @(negedge clk); pins = 32'h20;
    idle(2);
    pins = 32'h0;
    idle(40);
    rd(7'h24, v); chk("R11 short pulse filtered from status", v, 0);
    rd(7'h0C, v); chk("R11 filtered view after pulse", v, 0);
    @(negedge clk); pins = 32'h20;
    idle(30);
    rd(7'h0C, v); chk("R11 filtered view after long level", v, 32'h20);
    rd(7'h24, v); chk("R11 status after long level", v, 32'h20);
    chk("R11 irq from debounced line", {31'b0, irq}, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_dout;
    t_setclr;
    t_din;
    t_pull;
    t_trig;
    t_clear;
    t_mask;
    t_enable;
    t_debounce;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule